// File: doc/BRIEF.md
# Clock-Stop Serial Peripheral Master

This block is the master side of a four-wire serial peripheral link whose serial clock rests low and only toggles while a word is being exchanged. A host places a parallel word and an 8-bit divide setting on its inputs and pulses `start`. The block then pulls the active-low select line down, produces a gapped serial clock, shifts the word out MSB first on a data line that can be released to high impedance, and collects one bit from `miso` on each rising clock edge. When the select line goes high again it presents the received word with a one-cycle `done` pulse.

All serial timing comes from a generator tick, which is the system clock divided by a fixed prescale (6 by default). One serial-clock period is (1 + D) ticks, where D is the divide setting latched at `start`. If D is even, the high phase is D/2 + 1 ticks and the low phase is D/2 ticks. If D is odd, each phase is (D + 1)/2 ticks. A setting of 0 is treated as 1. The select line falls one full period before the first rising edge. The data line starts to drive one high-phase width after select falls. Select is released one low-phase width after the last falling edge.

The controller has six states: `ST_IDLE`, `ST_SEL_Z`, `ST_SEL_DRV`, `ST_CLK_HI`, `ST_CLK_LO` and `ST_TAIL`. Its transitions are: IDLE to SEL_Z on an accepted start; SEL_Z to SEL_DRV after the high-phase width; SEL_DRV to CLK_HI after the low-phase width, which is the first rising edge; CLK_HI to CLK_LO after the high-phase width, which is a falling edge; CLK_LO to CLK_HI after the low-phase width, which is the next rising edge; CLK_HI to TAIL after the last bit's high phase; TAIL to IDLE after the low-phase width.

Top module: `spi_cs_master`

## Requirements
- R1: After reset, `cs_n`=1, `sck`=0, `mosi_oe`=0, `busy`=0 and `done`=0.
- R2: For an even divide setting D, every high phase of `sck` lasts 6·(D/2+1) system cycles and every low phase between two high phases lasts 6·(D/2) cycles.
- R3: For an odd divide setting D, every high and low phase of `sck` lasts 6·(D+1)/2 system cycles.
- R4: A divide setting of 0 gives the same timing as a setting of 1, which is 6 cycles high and 6 cycles low.
- R5: `cs_n` is low for exactly one full serial period, 6·(D+1) cycles, before the first rising edge of `sck`.
- R6: `mosi_oe` stays 0 for one high-phase width after `cs_n` falls and then becomes 1.
- R7: The bits of `tx_word` appear on `mosi` MSB first. `mosi` only changes after falling edges of `sck` and is stable while `sck` is high.
- R8: `miso` is sampled on each rising edge of `sck`. The first sample becomes the MSB of `rx_word`.
- R9: After the last falling edge, `mosi_oe` is 0, and `cs_n` rises one low-phase width (6·L cycles) later. Exactly WORD_W rising edges occur per transfer.
- R10: `done` is high for exactly one cycle, in the first cycle in which `cs_n` is high again, and `rx_word` holds the received word from that cycle on. `busy` is high from the cycle after the accepted start until that cycle.
- R11: A `start` pulse while `busy` is high is ignored. The word in progress is unchanged and no second transfer follows.
- R12: `sck` is low whenever `cs_n` is high, and `mosi_oe` is 0 whenever `cs_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transfer (accepted only when idle) |
| tx_word | input | WORD_W | Word to send, latched at start |
| div_sel | input | DIV_W | Divide setting D, latched at start |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rx_word | output | WORD_W | Last received word |
| cs_n | output | 1 | Active-low slave select |
| sck | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out value |
| mosi_oe | output | 1 | Output enable for mosi (0 = high impedance) |
| miso | input | 1 | Serial data in |

## Verification
Some properties are checked by the bound assertions on every cycle. These are: the clock and output enable stay quiet while select is high; `mosi` holds steady through each high phase; `done` is a single-cycle pulse that coincides with select rising; the output enable is off at the moment select releases. Phase widths, the full-period lead, the delayed data enable, the tail width, bit order, received data and the ignored start while busy can only be shown by the bench's transfers. The bench measures these in system cycles for even, odd, zero and random divide settings.

// File: rtl/spi_cs_pkg.sv
package spi_cs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_SEL_Z   = 3'd1,
        ST_SEL_DRV = 3'd2,
        ST_CLK_HI  = 3'd3,
        ST_CLK_LO  = 3'd4,
        ST_TAIL    = 3'd5
    } xfer_state_t;

endpackage

// File: rtl/spi_cs_prescale.sv
module spi_cs_prescale #(
    parameter int PRESCALE = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic tick
);
    localparam int CW = (PRESCALE > 2) ? $clog2(PRESCALE) : 1;
    localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

    logic [CW-1:0] cnt_q;

    assign tick = (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear || tick) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/spi_cs_phase_calc.sv
module spi_cs_phase_calc #(
    parameter int DIV_W = 8
) (
    input  logic [DIV_W-1:0] div_val,
    output logic [DIV_W-1:0] hi_len,
    output logic [DIV_W-1:0] lo_len
);
    logic [DIV_W-1:0] d_eff;
    logic [DIV_W:0]   d_plus;

    always_comb begin
        d_eff  = (div_val == '0) ? DIV_W'(1) : div_val;
        d_plus = {1'b0, d_eff} + 1'b1;
        if (d_eff[0]) begin
            hi_len = d_plus[DIV_W:1];
            lo_len = d_plus[DIV_W:1];
        end else begin
            hi_len = d_eff[DIV_W-1:1] + 1'b1;
            lo_len = {1'b0, d_eff[DIV_W-1:1]};
        end
    end
endmodule

// File: rtl/spi_cs_shift.sv
module spi_cs_shift #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [WORD_W-1:0] load_word,
    input  logic              shift_tx,
    input  logic              sample_rx,
    input  logic              rx_bit,
    output logic              tx_msb,
    output logic [WORD_W-1:0] rx_shift
);
    logic [WORD_W-1:0] tx_q;
    logic [WORD_W-1:0] rx_q;

    assign tx_msb   = tx_q[WORD_W-1];
    assign rx_shift = rx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q <= '0;
            rx_q <= '0;
        end else begin
            if (load) begin
                tx_q <= load_word;
            end else if (shift_tx) begin
                tx_q <= {tx_q[WORD_W-2:0], 1'b0};
            end
            if (sample_rx) begin
                rx_q <= {rx_q[WORD_W-2:0], rx_bit};
            end
        end
    end
endmodule

// File: rtl/spi_cs_master.sv
module spi_cs_master
    import spi_cs_pkg::*;
#(
    parameter int WORD_W   = 8,
    parameter int DIV_W    = 8,
    parameter int PRESCALE = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [WORD_W-1:0] tx_word,
    input  logic [DIV_W-1:0]  div_sel,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rx_word,
    output logic              cs_n,
    output logic              sck,
    output logic              mosi,
    output logic              mosi_oe,
    input  logic              miso
);
    localparam int BW = (WORD_W > 2) ? $clog2(WORD_W) : 1;

    xfer_state_t       state_q, state_d;
    logic [DIV_W-1:0]  div_q;
    logic [DIV_W-1:0]  hi_len, lo_len, cur_len;
    logic [DIV_W-1:0]  ph_cnt_q;
    logic [BW-1:0]     bit_q;
    logic              tick, phase_end, accept;
    logic              last_bit;
    logic              tx_msb;
    logic [WORD_W-1:0] rx_shift;

    assign accept   = start && (state_q == ST_IDLE);
    assign last_bit = (bit_q == '0);

    spi_cs_prescale #(.PRESCALE(PRESCALE)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .tick  (tick)
    );

    spi_cs_phase_calc #(.DIV_W(DIV_W)) u_phase (
        .div_val (div_q),
        .hi_len  (hi_len),
        .lo_len  (lo_len)
    );

    spi_cs_shift #(.WORD_W(WORD_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (accept),
        .load_word (tx_word),
        .shift_tx  (phase_end && state_q == ST_CLK_HI && !last_bit),
        .sample_rx (phase_end && (state_q == ST_SEL_DRV || state_q == ST_CLK_LO)),
        .rx_bit    (miso),
        .tx_msb    (tx_msb),
        .rx_shift  (rx_shift)
    );

    always_comb begin
        unique case (state_q)
            ST_SEL_Z, ST_CLK_HI: cur_len = hi_len;
            default:             cur_len = lo_len;
        endcase
    end

    assign phase_end = tick && (state_q != ST_IDLE) && (ph_cnt_q == cur_len - 1'b1);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (accept)    state_d = ST_SEL_Z;
            ST_SEL_Z:   if (phase_end) state_d = ST_SEL_DRV;
            ST_SEL_DRV: if (phase_end) state_d = ST_CLK_HI;
            ST_CLK_HI:  if (phase_end) state_d = last_bit ? ST_TAIL : ST_CLK_LO;
            ST_CLK_LO:  if (phase_end) state_d = ST_CLK_HI;
            ST_TAIL:    if (phase_end) state_d = ST_IDLE;
            default:                   state_d = ST_IDLE;
        endcase
    end

    // State register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            div_q    <= DIV_W'(1);
            ph_cnt_q <= '0;
            bit_q    <= '0;
            done     <= 1'b0;
            rx_word  <= '0;
        end else begin
            state_q <= state_d;
            done    <= 1'b0;
            if (accept) begin
                div_q    <= div_sel;
                ph_cnt_q <= '0;
                bit_q    <= BW'(WORD_W - 1);
            end else if (phase_end) begin
                ph_cnt_q <= '0;
                if (state_q == ST_CLK_HI && !last_bit) begin
                    bit_q <= bit_q - 1'b1;
                end
                if (state_q == ST_TAIL) begin
                    done    <= 1'b1;
                    rx_word <= rx_shift;
                end
            end else if (tick && state_q != ST_IDLE) begin
                ph_cnt_q <= ph_cnt_q + 1'b1;
            end
        end
    end

    // Output decode
    always_comb begin
        cs_n    = 1'b0;
        sck     = 1'b0;
        mosi_oe = 1'b0;
        busy    = 1'b1;
        unique case (state_q)
            ST_IDLE: begin
                cs_n = 1'b1;
                busy = 1'b0;
            end
            ST_SEL_Z:   ;
            ST_SEL_DRV: mosi_oe = 1'b1;
            ST_CLK_HI: begin
                sck     = 1'b1;
                mosi_oe = 1'b1;
            end
            ST_CLK_LO:  mosi_oe = 1'b1;
            ST_TAIL:    ;
            default:    ;
        endcase
        mosi = mosi_oe & tx_msb;
    end
endmodule

// File: rtl/spi_cs_master_chk.sv
module spi_cs_master_chk (
    input logic clk,
    input logic rst_n,
    input logic busy,
    input logic done,
    input logic cs_n,
    input logic sck,
    input logic mosi,
    input logic mosi_oe
);
    // R12
    quiet_sck_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> (!sck && !mosi_oe));

    // R7
    mosi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(mosi));

    // R10
    done_at_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cs_n && !busy && $past(!cs_n)));

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    release_hiz_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> $past(!mosi_oe && !sck));
endmodule

bind spi_cs_master spi_cs_master_chk chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .busy    (busy),
    .done    (done),
    .cs_n    (cs_n),
    .sck     (sck),
    .mosi    (mosi),
    .mosi_oe (mosi_oe)
);

// File: tb/spi_cs_master_tb_top.sv
module spi_cs_master_tb_top;
    localparam int W   = 8;
    localparam int DW  = 8;
    localparam int PRE = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [W-1:0]  tx_word = '0;
    logic [DW-1:0] div_sel = '0;
    logic          busy, done, cs_n, sck, mosi, mosi_oe;
    logic [W-1:0]  rx_word;
    logic          miso = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    spi_cs_master #(.WORD_W(W), .DIV_W(DW), .PRESCALE(PRE)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_word(tx_word),
        .div_sel(div_sel), .busy(busy), .done(done), .rx_word(rx_word),
        .cs_n(cs_n), .sck(sck), .mosi(mosi), .mosi_oe(mosi_oe), .miso(miso)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int hi_ticks(input int dv);
        int d = (dv == 0) ? 1 : dv;
        return (d % 2 == 1) ? (d + 1) / 2 : d / 2 + 1;
    endfunction

    function automatic int lo_ticks(input int dv);
        int d = (dv == 0) ? 1 : dv;
        return (d % 2 == 1) ? (d + 1) / 2 : d / 2;
    endfunction

    task automatic do_xfer(input logic [W-1:0] word, input logic [W-1:0] slv,
                           input int dv, input string ptag, input bit poke);
        int h, l, lead, oe_off, rises, falls, tail, bad_hi, bad_lo, hi_run, lo_run, cyc, busy_bad;
        bit prev_sck, tail_oe_bad, early_busy;
        logic [W-1:0] got;
        h = hi_ticks(dv) * PRE;
        l = lo_ticks(dv) * PRE;
        lead = 0; oe_off = 0; rises = 0; falls = 0; tail = 0; bad_hi = 0; bad_lo = 0;
        hi_run = 0; lo_run = 0; cyc = 0; busy_bad = 0; prev_sck = 0; tail_oe_bad = 0; got = '0;
        @(negedge clk);
        tx_word = word; div_sel = DW'(dv); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        early_busy = busy;
        while (!cs_n && cyc < 100000) begin
            if (!busy) busy_bad++;
            if (sck) begin
                if (!prev_sck) begin
                    rises++;
                    got = {got[W-2:0], mosi};
                    if (rises > 1 && lo_run != l) bad_lo++;
                    lo_run = 0;
                end
                hi_run++;
            end else begin
                if (prev_sck) begin
                    falls++;
                    if (hi_run != h) bad_hi++;
                    hi_run = 0;
                end
                if (rises == 0) begin
                    lead++;
                    if (!mosi_oe) oe_off++;
                end else if (falls == W) begin
                    tail++;
                    if (mosi_oe) tail_oe_bad = 1;
                end else begin
                    lo_run++;
                end
            end
            miso = (falls < W) ? slv[W-1-falls] : 1'b0;
            prev_sck = sck;
            if (poke && cyc == 10) begin start = 1'b1; tx_word = ~word; end
            if (poke && cyc == 11) start = 1'b0;
            cyc++;
            @(negedge clk);
        end
        check({"R10 busy during transfer ", ptag}, int'(early_busy) + (busy_bad == 0 ? 1 : 0), 2);
        check({"R5 lead ", ptag}, lead, h + l);
        check({"R6 data enable delay ", ptag}, oe_off, h);
        check({ptag, " high phases"}, bad_hi, 0);
        check({ptag, " low phases"}, bad_lo, 0);
        check({"R9 rising edge count ", ptag}, rises, W);
        check({"R7 MSB-first bits ", ptag}, int'(got), int'(word));
        check({"R9 tail width ", ptag}, tail, l);
        check({"R9 tail hi-z ", ptag}, int'(tail_oe_bad), 0);
        check({"R10 done at release ", ptag}, int'(done), 1);
        check({"R8 rx_word ", ptag}, int'(rx_word), int'(slv));
        @(negedge clk);
        check({"R10 done one cycle ", ptag}, int'(done), 0);
        if (poke) begin
            int woke = 0;
            for (int i = 0; i < 20; i++) begin
                @(negedge clk);
                if (!cs_n || busy) woke++;
            end
            check("R11 no second transfer after busy start", woke, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1 cs_n reset", int'(cs_n), 1);
        check("R1 sck reset", int'(sck), 0);
        check("R1 mosi_oe reset", int'(mosi_oe), 0);
        check("R1 busy/done reset", int'(busy) + int'(done), 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R12 idle quiet", int'(sck) + int'(mosi_oe) + int'(!cs_n), 0);

        do_xfer(8'hA5, 8'h3C, 4, "R2 even D=4", 1'b0);
        do_xfer(8'h81, 8'hC3, 2, "R2 even D=2", 1'b0);
        do_xfer(8'h5A, 8'h96, 5, "R3 odd D=5", 1'b0);
        do_xfer(8'hFF, 8'h00, 1, "R3 odd D=1", 1'b0);
        do_xfer(8'h01, 8'h80, 0, "R4 clamp D=0", 1'b0);
        do_xfer(8'hC6, 8'h5B, 3, "R11 start while busy", 1'b1);

        void'($urandom(32'h1D5C));
        for (int k = 0; k < 10; k++) begin
            logic [W-1:0] a, b;
            int dv;
            a  = W'($urandom);
            b  = W'($urandom);
            dv = int'($urandom % 16);
            do_xfer(a, b, dv, (dv % 2 == 0) ? "R2 random even" : "R3 random odd", 1'b0);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule